// File: doc/BRIEF.md
# Logic and Increment Flag Unit

This unit performs the bitwise OR, XOR and AND operations and the increment and decrement operations of an 8-bit accumulator datapath. For each result it builds the processor status byte: sign, zero, parity, half-carry, a decrement marker and carry. A registered wrapper holds the accumulator and the status byte. Both are updated on any cycle where the strobe is high.

The half-carry rule for AND depends on a variant select input. The later variant always reports half-carry after AND. The early variant takes half-carry from bit 3 of the OR of both operands. Because of this, the same AND can leave different status bytes on the two variants.

Logical operations take the accumulator and `operand_i`. Increment and decrement act on the accumulator. Two load codes place a value into the accumulator or into the status byte, so that any state can be reached.

Top module: `logic_flag_unit`

## Requirements
- R1: While `rst_ni` is low, `acc_o` and `flags_o` read 0x00.
- R2: While `valid_i` is low, or when `op_i` is 7 (reserved), `acc_o` and `flags_o` hold their values across the clock edge.
- R3: `op_i`=0 (OR) and `op_i`=1 (XOR) write the result to the accumulator. Only sign, zero and parity are taken from the result; half-carry, the decrement marker and carry become 0.
- R4: `op_i`=2 (AND) with `variant_i`=1 sets half-carry, in addition to sign, zero and parity from the result.
- R5: `op_i`=2 (AND) with `variant_i`=0 sets half-carry equal to bit 3 of (accumulator OR operand), taken before the AND.
- R6: `op_i`=3 (increment) sets half-carry only when the old low nibble was 0xF. It keeps the old carry and clears the decrement marker.
- R7: `op_i`=4 (decrement) sets half-carry when the old low nibble was not zero. It sets the decrement marker and keeps the old carry.
- R8: After an operation with code 0 to 4, parity (bit 2) is 1 exactly when the result has an even count of one bits.
- R9: Increment and decrement wrap modulo 256. 0xFF+1 gives 0x00 with zero set, and 0x00-1 gives 0xFF with sign set.
- R10: The status byte layout is: sign bit 7, zero bit 6, half-carry bit 4, parity bit 2, decrement marker bit 1, carry bit 0. Bits 5 and 3 always read 0.
- R11: `op_i`=5 loads `operand_i` into the status byte, with bits 5 and 3 forced to 0. `op_i`=6 loads `operand_i` into the accumulator and leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| variant_i | input | 1 | 0 early variant, 1 later variant |
| operand_i | input | 8 | Second operand or load value |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Status byte |

## Verification
A wrong half-carry or parity term appears in `flags_o` on the first clock edge after the faulty operation. Because the status byte is only replaced by the next operation, the error stays visible until then. A lost carry is more delayed: it shows after an increment or decrement that follows a status load with carry set. A wrong wrap or a wrong result shows at once in `acc_o`, and it propagates into every later operation.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  parameter int DATA_W = 8;
  localparam int NIB_W = DATA_W / 2;
  localparam int FB_S = 7;
  localparam int FB_Z = 6;
  localparam int FB_H = 4;
  localparam int FB_P = 2;
  localparam int FB_V = 1;
  localparam int FB_C = 0;
  localparam logic [7:0] FLAG_MASK = 8'b1101_0111;

  typedef enum logic [2:0] {
    OP_OR  = 3'd0,
    OP_XOR = 3'd1,
    OP_AND = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4,
    OP_LDF = 3'd5,
    OP_LDA = 3'd6,
    OP_NOP = 3'd7
  } op_e;

  // sign, zero and even parity of a result, other bits clear
  function automatic logic [7:0] szp(input logic [DATA_W-1:0] r);
    logic [7:0] f;
    f = '0;
    f[FB_S] = r[DATA_W-1];
    f[FB_Z] = (r == '0);
    f[FB_P] = ~^r;
    return f;
  endfunction
endpackage

// File: rtl/lfu_logic.sv
module lfu_logic
  import lfu_pkg::*;
(
  input  op_e               op_i,
  input  logic              late_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic [7:0]        flags_o
);
  logic [DATA_W-1:0] or_v;
  assign or_v = a_i | b_i;

  always_comb begin
    unique case (op_i)
      OP_XOR:  res_o = a_i ^ b_i;
      OP_AND:  res_o = a_i & b_i;
      default: res_o = or_v;
    endcase
    flags_o = szp(res_o);
    if (op_i == OP_AND) flags_o[FB_H] = late_i ? 1'b1 : or_v[3];
  end
endmodule

// File: rtl/lfu_incdec.sv
module lfu_incdec
  import lfu_pkg::*;
(
  input  logic              dec_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic [7:0]        flags_o
);
  logic nib_full, nib_zero;
  assign nib_full = &a_i[NIB_W-1:0];
  assign nib_zero = ~|a_i[NIB_W-1:0];

  always_comb begin
    res_o = dec_i ? a_i - 1'b1 : a_i + 1'b1;
    flags_o = szp(res_o);
    flags_o[FB_C] = carry_i;
    flags_o[FB_H] = dec_i ? ~nib_zero : nib_full;
    flags_o[FB_V] = dec_i;
  end
endmodule

// File: rtl/logic_flag_unit.sv
module logic_flag_unit
  import lfu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic              variant_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [7:0]        flags_o
);
  op_e op;
  logic [DATA_W-1:0] acc_q, acc_d, lg_res, id_res;
  logic [7:0] flags_q, flags_d, lg_flags, id_flags;

  assign op = op_e'(op_i);

  lfu_logic u_logic (
    .op_i   (op),
    .late_i (variant_i),
    .a_i    (acc_q),
    .b_i    (operand_i),
    .res_o  (lg_res),
    .flags_o(lg_flags)
  );

  lfu_incdec u_incdec (
    .dec_i  (op == OP_DEC),
    .a_i    (acc_q),
    .carry_i(flags_q[FB_C]),
    .res_o  (id_res),
    .flags_o(id_flags)
  );

  always_comb begin
    acc_d   = acc_q;
    flags_d = flags_q;
    unique case (op)
      OP_OR, OP_XOR, OP_AND: begin acc_d = lg_res; flags_d = lg_flags; end
      OP_INC, OP_DEC:        begin acc_d = id_res; flags_d = id_flags; end
      OP_LDF:                flags_d = operand_i[7:0] & FLAG_MASK;
      OP_LDA:                acc_d = operand_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (valid_i) begin
      acc_q   <= acc_d;
      flags_q <= flags_d;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flags_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i == 3'd7) |=> ($stable(acc_o) && $stable(flags_o)));
  p_logic_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd1) |=> (flags_o[FB_H] == 1'b0 && flags_o[FB_C] == 1'b0 && flags_o[FB_V] == 1'b0));
  p_and_late_h_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && variant_i) |=> flags_o[FB_H]);
  p_inc_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=> (flags_o[FB_C] == $past(flags_o[FB_C]) && !flags_o[FB_V]));
  p_dec_mark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (flags_o[FB_V] && flags_o[FB_C] == $past(flags_o[FB_C])));
  p_parity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd4) |=> (flags_o[FB_P] == ~^acc_o && flags_o[FB_Z] == (acc_o == '0)));
  p_fixed_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[5] == 1'b0 && flags_o[3] == 1'b0));
endmodule

// File: tb/logic_flag_unit_tb.sv
`timescale 1ns/1ps
module logic_flag_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, variant = 1'b0;
  logic [2:0] op = 3'd7;
  logic [7:0] opnd = 8'h00;
  logic [7:0] acc, flags;
  logic [7:0] m_acc = 8'h00, m_flags = 8'h00;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic_flag_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .variant_i(variant), .operand_i(opnd), .acc_o(acc), .flags_o(flags)
  );

  function automatic logic [7:0] zsp(input logic [7:0] r);
    return {r[7], r == 8'h00, 1'b0, 1'b0, 1'b0, ~^r, 1'b0, 1'b0};
  endfunction

  function automatic string tag_of(input logic v, input logic [2:0] o, input logic late);
    if (!v || o == 3'd7) return "R2";
    case (o)
      3'd0, 3'd1: return "R3";
      3'd2:       return late ? "R4" : "R5";
      3'd3:       return "R6";
      3'd4:       return "R7";
      default:    return "R11";
    endcase
  endfunction

  task automatic model(input logic v, input logic [2:0] o, input logic late, input logic [7:0] b);
    logic [7:0] a, f, r;
    a = m_acc; f = m_flags; r = a;
    if (!v) return;
    case (o)
      3'd0: begin r = a | b; f = zsp(r); end
      3'd1: begin r = a ^ b; f = zsp(r); end
      3'd2: begin r = a & b; f = zsp(r); f[4] = late ? 1'b1 : (a[3] | b[3]); end
      3'd3: begin r = a + 8'd1; f = zsp(r) | {3'b0, a[3:0] == 4'hF, 3'b0, m_flags[0]}; end
      3'd4: begin r = a - 8'd1; f = zsp(r) | {3'b0, a[3:0] != 4'h0, 2'b0, 1'b1, m_flags[0]}; end
      3'd5: f = b & 8'hD7;
      3'd6: r = b;
      default: ;
    endcase
    m_acc = r; m_flags = f;
  endtask

  task automatic check(input string tag, input logic [7:0] ea, input logic [7:0] ef);
    total++;
    if (acc !== ea || flags !== ef) begin
      bad++;
      $display("FAIL %s: acc=%02h flags=%02h expected acc=%02h flags=%02h", tag, acc, flags, ea, ef);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] o, input logic late, input logic [7:0] b, input string tag);
    valid = v; op = o; variant = late; opnd = b;
    model(v, o, late, b);
    @(negedge clk);
    check(tag, m_acc, m_flags);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 3'd0, 1'b0, 8'hFF, "R2");
    step(1'b1, 3'd7, 1'b0, 8'hFF, "R2");
    step(1'b1, 3'd0, 1'b0, 8'h03, "R8");      // two ones, even parity
    step(1'b1, 3'd1, 1'b0, 8'h02, "R8");      // 0x01 odd parity
    step(1'b1, 3'd1, 1'b0, 8'h01, "R3");      // zero result
    step(1'b1, 3'd6, 1'b0, 8'hF0, "R11");
    step(1'b1, 3'd2, 1'b0, 8'h08, "R5");      // bit3 from operand -> H
    step(1'b1, 3'd6, 1'b0, 8'hF0, "R11");
    step(1'b1, 3'd2, 1'b0, 8'h07, "R5");      // no bit3 -> H clear
    step(1'b1, 3'd2, 1'b1, 8'h07, "R4");
    step(1'b1, 3'd5, 1'b0, 8'hFF, "R10");     // flags 0xD7, carry set
    step(1'b1, 3'd6, 1'b0, 8'hFF, "R11");
    step(1'b1, 3'd3, 1'b0, 8'h00, "R9");      // FF+1 -> 00, Z, H, C kept
    step(1'b1, 3'd4, 1'b0, 8'h00, "R9");      // 00-1 -> FF, S, V, no H
    step(1'b1, 3'd6, 1'b0, 8'h10, "R11");
    step(1'b1, 3'd4, 1'b0, 8'h00, "R7");      // low nibble zero -> no H
    step(1'b1, 3'd3, 1'b0, 8'h00, "R6");      // 0x0F -> 0x10 with H
    step(1'b1, 3'd3, 1'b0, 8'h00, "R6");
    step(1'b1, 3'd0, 1'b0, 8'h00, "R3");      // clears carry
    for (int i = 0; i < 3000; i++) begin
      logic v, late;
      logic [2:0] o;
      logic [7:0] b;
      v = ($urandom % 10) != 0;
      o = 3'($urandom % 8);
      late = 1'($urandom);
      b = 8'($urandom);
      step(v, o, late, b, tag_of(v, o, late));
      total++;
      if (flags[5] !== 1'b0 || flags[3] !== 1'b0) begin
        bad++;
        $display("FAIL R10: flags=%02h expected bits 5,3 zero", flags);
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule